// File: doc/BRIEF.md
# Argmax Result Packet Transmitter

This block sits at the output of a small classifier. When the inference engine finishes, it presents ten signed 8-bit scores and pulses a start request. The block latches the scores and finds the class with the highest score. It then sends a fixed 13-byte reply over a serial line: an opening marker, the winning class, the ten scores in class order, and a closing marker.

Inside, a chain of signed comparators picks the winner. A byte sequencer walks the packet one slot at a time. An 8N1 serial transmitter takes each byte through a ready/valid handshake. The sequencer hands over the next byte only when the transmitter reports that it is idle. The busy output stays high from the accepted request until the closing byte's stop bit has ended. Start requests that arrive while busy is high are dropped.

The clock frequency and the line rate are parameters. At the defaults, 100 MHz and 115,200 baud, each bit lasts 868 clock cycles.

Top module: `logit_reply_tx`

## Requirements
- R1: While reset is held and after it is released, `busy_o` is 0 and `txd_o` is 1.
- R2: A start request sampled with `busy_o` low is accepted, and `busy_o` is 1 in the next cycle. Each byte of the reply is framed as one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts CLK_HZ/BAUD cycles.
- R3: The reply is exactly 13 bytes long. The first byte is 0xBB and the last byte is 0x66.
- R4: The second byte is the index (0 to 9, zero-extended to 8 bits) of the largest score. Scores are compared as two's-complement values.
- R5: When several scores share the largest value, the second byte is the lowest of their indices.
- R6: Bytes 3 to 12 are the scores in class order, score 0 first. Each score is sent as its raw 8-bit pattern, as it was latched when the request was accepted. Changes on `logits_i` after acceptance have no effect.
- R7: A start request while `busy_o` is high is ignored. The reply in flight keeps its contents, and no second reply follows it.
- R8: `busy_o` stays 1 until the stop bit of the last byte has completed. A request held high across the end of a reply is accepted in the first cycle that `busy_o` is low.
- R9: Whenever `busy_o` is 0, `txd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to send a reply for the scores on `logits_i` |
| logits_i | input | NUM_CLASS*LOGIT_W (80) | Scores; class k occupies bits [8k+7:8k] |
| busy_o | output | 1 | High while a reply is being sent |
| txd_o | output | 1 | Serial data line, idle high |

## Verification
Two events can meet in one cycle: the return to idle after the closing stop bit, and a new start request. The bench holds start high through an entire reply with different scores on the inputs. The reply in flight must still carry the first set of scores. The second set must be accepted in the very first cycle that busy reads low, and the bench checks that busy is high again one cycle later. Single-cycle requests injected in the middle of a reply must leave that reply unchanged and must not produce any trailing traffic.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_SEND  = 2'd1,
      SQ_DRAIN = 2'd2
   } seq_state_t;

   localparam int BITS_PER_FRAME = 10;

endpackage

// File: rtl/lrt_argmax.sv
module lrt_argmax #(
   parameter int NUM_CLASS = 10,
   parameter int LOGIT_W   = 8,
   parameter int CLS_W     = $clog2(NUM_CLASS)
) (
   input  logic [NUM_CLASS*LOGIT_W-1:0] bank_i,
   output logic [CLS_W-1:0]             win_o
);

   // Linear chain; a strict greater-than keeps the earlier index on ties
   for (genvar g = 0; g < NUM_CLASS; g++) begin : g_st
      logic signed [LOGIT_W-1:0] v;
      logic        [CLS_W-1:0]   ix;
      if (g == 0) begin : g_first
         assign v  = bank_i[LOGIT_W-1:0];
         assign ix = '0;
      end else begin : g_next
         logic signed [LOGIT_W-1:0] cand;
         logic                      take;
         assign cand = bank_i[g*LOGIT_W +: LOGIT_W];
         assign take = cand > g_st[g-1].v;
         assign v    = take ? cand : g_st[g-1].v;
         assign ix   = take ? CLS_W'(g) : g_st[g-1].ix;
      end
   end

   assign win_o = g_st[NUM_CLASS-1].ix;

endmodule

// File: rtl/lrt_uart_tx.sv
module lrt_uart_tx #(
   parameter int BIT_CYC = 868
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] data_i,
   input  logic       valid_i,
   output logic       ready_o,
   output logic       txd_o
);

   localparam int CNT_W   = $clog2(BIT_CYC);
   localparam int LAST_BIT = lrt_pkg::BITS_PER_FRAME - 1;

   logic             active_q;
   logic [CNT_W-1:0] baud_q;
   logic [3:0]       bit_q;
   logic [8:0]       sh_q;
   logic             txd_q;
   logic             bit_end;

   assign bit_end = (baud_q == CNT_W'(BIT_CYC - 1));
   assign ready_o = !active_q;
   assign txd_o   = txd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         baud_q   <= '0;
         bit_q    <= '0;
         sh_q     <= '1;
         txd_q    <= 1'b1;
      end else if (!active_q) begin
         if (valid_i) begin
            active_q <= 1'b1;
            baud_q   <= '0;
            bit_q    <= '0;
            sh_q     <= {1'b1, data_i};
            txd_q    <= 1'b0;
         end
      end else if (bit_end) begin
         baud_q <= '0;
         if (bit_q == 4'(LAST_BIT)) begin
            active_q <= 1'b0;
         end else begin
            bit_q <= bit_q + 4'd1;
            txd_q <= sh_q[0];
            sh_q  <= {1'b1, sh_q[8:1]};
         end
      end else begin
         baud_q <= baud_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/lrt_seq.sv
module lrt_seq
   import lrt_pkg::*;
#(
   parameter int             NUM_CLASS = 10,
   parameter int             LOGIT_W   = 8,
   parameter int             CLS_W     = $clog2(NUM_CLASS),
   parameter logic [7:0]     HDR_BYTE  = 8'hBB,
   parameter logic [7:0]     TRL_BYTE  = 8'h66
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [NUM_CLASS*LOGIT_W-1:0] logits_i,
   input  logic [CLS_W-1:0]             win_i,
   output logic [NUM_CLASS*LOGIT_W-1:0] bank_o,
   output logic                         busy_o,
   output logic [LOGIT_W-1:0]           byte_o,
   output logic                         byte_vld_o,
   input  logic                         byte_rdy_i
);

   localparam int NBYTES = NUM_CLASS + 3;
   localparam int IDX_W  = $clog2(NBYTES);

   seq_state_t                   st_q;
   logic [IDX_W-1:0]             idx_q;
   logic [NUM_CLASS*LOGIT_W-1:0] bank_q;
   logic                         accept;
   logic                         last;
   logic [LOGIT_W-1:0]           slot [NUM_CLASS];
   logic [CLS_W-1:0]             lsel;

   assign accept     = start_i && (st_q == SQ_IDLE);
   assign last       = (idx_q == IDX_W'(NBYTES - 1));
   assign byte_vld_o = (st_q == SQ_SEND) && byte_rdy_i;
   assign busy_o     = (st_q != SQ_IDLE);
   assign bank_o     = bank_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         idx_q  <= '0;
         bank_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: if (accept) begin
               bank_q <= logits_i;
               idx_q  <= '0;
               st_q   <= SQ_SEND;
            end
            SQ_SEND: if (byte_vld_o) begin
               if (last) st_q  <= SQ_DRAIN;
               else      idx_q <= idx_q + IDX_W'(1);
            end
            SQ_DRAIN: if (byte_rdy_i) st_q <= SQ_IDLE;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_CLASS; g++) begin : g_slot
      assign slot[g] = bank_q[g*LOGIT_W +: LOGIT_W];
   end

   assign lsel = CLS_W'(idx_q - IDX_W'(2));

   always_comb begin
      if (idx_q == '0)              byte_o = HDR_BYTE;
      else if (idx_q == IDX_W'(1))  byte_o = LOGIT_W'(win_i);
      else if (last)                byte_o = TRL_BYTE;
      else                          byte_o = slot[lsel];
   end

endmodule

// File: rtl/logit_reply_tx.sv
module logit_reply_tx #(
   parameter int         CLK_HZ    = 100_000_000,
   parameter int         BAUD      = 115_200,
   parameter int         NUM_CLASS = 10,
   parameter int         LOGIT_W   = 8,
   parameter logic [7:0] HDR_BYTE  = 8'hBB,
   parameter logic [7:0] TRL_BYTE  = 8'h66
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [NUM_CLASS*LOGIT_W-1:0] logits_i,
   output logic                         busy_o,
   output logic                         txd_o
);

   localparam int BIT_CYC = CLK_HZ / BAUD;
   localparam int CLS_W   = $clog2(NUM_CLASS);

   if (BIT_CYC < 2) begin : g_bad_rate
      $error("logit_reply_tx: CLK_HZ/BAUD must be at least 2");
   end
   if (LOGIT_W != 8) begin : g_bad_width
      $error("logit_reply_tx: scores must be byte wide");
   end
   if (NUM_CLASS < 2 || NUM_CLASS > 128) begin : g_bad_count
      $error("logit_reply_tx: NUM_CLASS out of range");
   end

   logic [NUM_CLASS*LOGIT_W-1:0] bank_q;
   logic [CLS_W-1:0]             win_idx;
   logic [LOGIT_W-1:0]           byte_dat;
   logic                         byte_vld;
   logic                         byte_rdy;

   lrt_argmax #(
      .NUM_CLASS (NUM_CLASS),
      .LOGIT_W   (LOGIT_W),
      .CLS_W     (CLS_W)
   ) u_argmax (
      .bank_i (bank_q),
      .win_o  (win_idx)
   );

   lrt_seq #(
      .NUM_CLASS (NUM_CLASS),
      .LOGIT_W   (LOGIT_W),
      .CLS_W     (CLS_W),
      .HDR_BYTE  (HDR_BYTE),
      .TRL_BYTE  (TRL_BYTE)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .logits_i   (logits_i),
      .win_i      (win_idx),
      .bank_o     (bank_q),
      .busy_o     (busy_o),
      .byte_o     (byte_dat),
      .byte_vld_o (byte_vld),
      .byte_rdy_i (byte_rdy)
   );

   lrt_uart_tx #(
      .BIT_CYC (BIT_CYC)
   ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_i  (byte_dat),
      .valid_i (byte_vld),
      .ready_o (byte_rdy),
      .txd_o   (txd_o)
   );

endmodule

// File: rtl/logit_reply_tx_chk.sv
module logit_reply_tx_chk #(
   parameter int NUM_CLASS = 10,
   parameter int LOGIT_W   = 8,
   parameter int CLS_W     = $clog2(NUM_CLASS)
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         start_i,
   input logic                         busy_o,
   input logic                         txd_o,
   input logic                         byte_vld,
   input logic                         byte_rdy,
   input logic [NUM_CLASS*LOGIT_W-1:0] bank,
   input logic [CLS_W-1:0]             win_idx
);

   logic [7:0]                hs_cnt;
   logic signed [LOGIT_W-1:0] win_val;

   assign win_val = bank[int'(win_idx)*LOGIT_W +: LOGIT_W];

   always_ff @(posedge clk) begin
      if (!rst_n)                     hs_cnt <= '0;
      else if (start_i && !busy_o)    hs_cnt <= '0;
      else if (byte_vld && byte_rdy)  hs_cnt <= hs_cnt + 8'd1;
   end

   // R2
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R9
   idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> txd_o);

   // R3
   byte_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (int'(hs_cnt) == NUM_CLASS + 3));

   // R7
   hs_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> busy_o);

   for (genvar k = 0; k < NUM_CLASS; k++) begin : g_cls
      // R4
      win_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
         busy_o |-> !($signed(bank[k*LOGIT_W +: LOGIT_W]) > win_val));
      // R5
      win_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (busy_o && ($signed(bank[k*LOGIT_W +: LOGIT_W]) == win_val))
            |-> (int'(win_idx) <= k));
   end

endmodule

bind logit_reply_tx logit_reply_tx_chk #(
   .NUM_CLASS (NUM_CLASS),
   .LOGIT_W   (LOGIT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .busy_o   (busy_o),
   .txd_o    (txd_o),
   .byte_vld (byte_vld),
   .byte_rdy (byte_rdy),
   .bank     (bank_q),
   .win_idx  (win_idx)
);

// File: tb/logit_reply_tx_tb.sv
module logit_reply_tx_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NC         = 10;
   localparam int TB_CLK_HZ  = 800;
   localparam int TB_BAUD    = 100;
   localparam int BIT        = TB_CLK_HZ / TB_BAUD;
   localparam int NBYTES     = NC + 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [NC*8-1:0] logits_i = '0;
   logic          busy_o;
   logic          txd_o;

   int checks = 0;
   int errors = 0;
   logic signed [7:0] cur [NC];
   logic [7:0]        exp_pkt [NBYTES];
   bit                tie_case;

   always #(CLK_PERIOD/2) clk = ~clk;

   logit_reply_tx #(
      .CLK_HZ    (TB_CLK_HZ),
      .BAUD      (TB_BAUD),
      .NUM_CLASS (NC),
      .LOGIT_W   (8)
   ) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .logits_i (logits_i),
      .busy_o   (busy_o),
      .txd_o    (txd_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int ref_class();
      int best = 0;
      for (int i = 1; i < NC; i++) if (cur[i] > cur[best]) best = i;
      return best;
   endfunction

   task automatic build_exp();
      int best = ref_class();
      int n = 0;
      for (int i = 0; i < NC; i++) if (cur[i] == cur[best]) n++;
      tie_case = (n > 1);
      exp_pkt[0] = 8'hBB;
      exp_pkt[1] = 8'(best);
      for (int i = 0; i < NC; i++) exp_pkt[i+2] = cur[i];
      exp_pkt[NBYTES-1] = 8'h66;
   endtask

   task automatic drive_cur();
      for (int i = 0; i < NC; i++) logits_i[i*8 +: 8] = cur[i];
   endtask

   task automatic scramble_inputs();
      for (int i = 0; i < NC; i++) logits_i[i*8 +: 8] = 8'($urandom);
   endtask

   task automatic rx_byte(output logic [7:0] b, output bit framed);
      int n = 0;
      b = '0;
      framed = 1'b1;
      while (txd_o === 1'b1 && n < BIT*40) begin
         @(negedge clk);
         n++;
      end
      if (txd_o !== 1'b0) begin
         framed = 1'b0;
         return;
      end
      repeat (BIT/2) @(negedge clk);
      if (txd_o !== 1'b0) framed = 1'b0;
      for (int i = 0; i < 8; i++) begin
         repeat (BIT) @(negedge clk);
         b[i] = txd_o;
      end
      repeat (BIT) @(negedge clk);
      if (txd_o !== 1'b1) framed = 1'b0;
   endtask

   task automatic rx_packet();
      logic [7:0] b;
      bit framed;
      for (int k = 0; k < NBYTES; k++) begin
         rx_byte(b, framed);
         check(framed, "R2", $sformatf("frame of byte %0d", k), framed, 1);
         if (k == 0 || k == NBYTES-1)
            check(b == exp_pkt[k], "R3", $sformatf("marker byte %0d", k), b, exp_pkt[k]);
         else if (k == 1 && tie_case)
            check(b == exp_pkt[k], "R5", "class on tie", b, exp_pkt[k]);
         else if (k == 1)
            check(b == exp_pkt[k], "R4", "class byte", b, exp_pkt[k]);
         else
            check(b == exp_pkt[k], "R6", $sformatf("score byte %0d", k), b, exp_pkt[k]);
      end
      check(busy_o == 1'b1, "R8", "busy during last stop bit", busy_o, 1);
   endtask

   task automatic wait_idle();
      int n = 0;
      int bad = 0;
      while (busy_o && n < 2*BIT) begin
         @(negedge clk);
         n++;
      end
      check(!busy_o, "R8", "busy falls after last stop bit", busy_o, 0);
      repeat (3*BIT) begin
         @(negedge clk);
         if (busy_o || !txd_o) bad++;
      end
      check(bad == 0, "R7,R9", "line idle after reply", bad, 0);
   endtask

   task automatic send(input bit inject);
      build_exp();
      drive_cur();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      check(busy_o == 1'b1, "R2", "busy after accept", busy_o, 1);
      scramble_inputs();
      if (inject) begin
         fork
            rx_packet();
            begin
               repeat (5*BIT) @(negedge clk);
               scramble_inputs();
               start_i = 1'b1;
               @(negedge clk) start_i = 1'b0;
               repeat (40*BIT) @(negedge clk);
               scramble_inputs();
               start_i = 1'b1;
               @(negedge clk) start_i = 1'b0;
            end
         join
      end else begin
         rx_packet();
      end
      wait_idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(busy_o == 1'b0 && txd_o == 1'b1, "R1", "state in reset",
            {busy_o, txd_o}, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(busy_o == 1'b0 && txd_o == 1'b1, "R1", "state after reset",
            {busy_o, txd_o}, 1);

      // R5: every score equal to zero
      for (int i = 0; i < NC; i++) cur[i] = 8'sd0;
      send(1'b0);
      // R5: every score at the negative limit
      for (int i = 0; i < NC; i++) cur[i] = -8'sd128;
      send(1'b1);
      // R4: ascending scores, winner is the last class
      for (int i = 0; i < NC; i++) cur[i] = 8'(i*10 - 40);
      send(1'b0);
      // R5: two equal maxima at classes 3 and 7
      for (int i = 0; i < NC; i++) cur[i] = 8'sd5;
      cur[3] = 8'sd100;
      cur[7] = 8'sd100;
      send(1'b0);
      // R4: all negative, largest is -1 at class 6
      for (int i = 0; i < NC; i++) cur[i] = -8'sd90;
      cur[6] = -8'sd1;
      send(1'b1);
      // R4: positive limit against negative limit (unsigned compare would fail)
      for (int i = 0; i < NC; i++) cur[i] = -8'sd128;
      cur[2] = 8'sd127;
      send(1'b0);

      for (int r = 0; r < 16; r++) begin
         for (int i = 0; i < NC; i++) cur[i] = 8'($urandom);
         send((r % 4) == 1);
      end

      // R8: start held high across the end of a reply
      for (int i = 0; i < NC; i++) cur[i] = 8'($urandom);
      build_exp();
      drive_cur();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk);
      check(busy_o == 1'b1, "R2", "busy after held accept", busy_o, 1);
      for (int i = 0; i < NC; i++) cur[i] = 8'($urandom);
      cur[8] = 8'sd127;
      drive_cur();
      rx_packet();
      while (busy_o) @(negedge clk);
      @(negedge clk);
      check(busy_o == 1'b1, "R8", "held start taken in first idle cycle", busy_o, 1);
      start_i = 1'b0;
      build_exp();
      rx_packet();
      wait_idle();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule